// File: doc/BRIEF.md
# Microcontroller Clock Output with Shutdown Tail

This block drives the clock pin of an external microcontroller. While the oscillator-enable bit is set it divides the reference clock (nominally 10 MHz) by a programmable ratio and presents the result on `mcu_clk_o`. When the sleep-clock select is set, a low-frequency clock of about 32 kHz is carried to the output instead. The change between the two sources is made only at an instant when both are low, so that no shortened pulse reaches the pin.

When software clears the oscillator-enable bit, the output does not stop at once. The block keeps the oscillator requested and delivers a programmable number of further output pulses, the tail, so that the microcontroller can finish its work and enter its own idle state. It then parks the output low and drops `osc_req_o`. If the enable bit is set again while a tail is running, the tail is abandoned and normal output continues without a break. The divide ratio and the tail length are loaded together with a configuration write strobe. After reset they hold their defaults: a ratio of 10 and a tail of 128 pulses.

The low-frequency clock is sampled into the reference domain through a synchronizer. At block level `clk_i` is treated as free-running, and `osc_req_o` is what asks the analog oscillator to keep it alive.

Top module: `mco_clk_out`

## Requirements
- R1: While `rst_ni` is low, `mcu_clk_o`, `osc_req_o` and `tail_active_o` are all 0, and the block is in the stopped state.
- R2: After reset, with no configuration write, the divide ratio is 10 and the tail length is 128 pulses.
- R3: While running on the divided source with ratio r, `mcu_clk_o` is high for floor(r/2) `clk_i` cycles and low for r - floor(r/2) cycles. The duty cycle is 50 percent for even r.
- R4: A cycle with `cfg_we_i`=1 loads `div_ratio_i` and `tail_len_i`. A ratio value below 2 is stored as 2.
- R5: After `osc_en_i` falls while running, `tail_active_o` is 1 from the next cycle on, and `mcu_clk_o` shows exactly N more rising edges, where N is the stored tail length. The rising edge in the cycle where the low enable is first seen counts as one of the N.
- R6: `osc_req_o` stays 1 until the last tail pulse has fallen. It then drops in a cycle in which `mcu_clk_o` is 0 and was 0 in the cycle before.
- R7: With a tail length of 0, no new pulse starts after disable, but a high pulse already in progress completes at its full length.
- R8: Setting `osc_en_i` again during a tail clears `tail_active_o` in the next cycle. `osc_req_o` never drops, and the divided output continues.
- R9: With `sleep_clk_en_i`=1, the output carries the synchronized low-frequency clock at its own high and low times. The source select changes only in a cycle where the divided clock and the synchronized low-frequency clock are both low, so no high pulse is shorter than the shorter high time of the two sources.
- R10: In the stopped state `mcu_clk_o` is held at 0. When `osc_en_i` rises, `osc_req_o` is 1 from the next cycle, and the first high output appears L+2 cycles after the enable is driven, where L = r - floor(r/2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lf_clk_i | input | 1 | Low-frequency sleep clock |
| osc_en_i | input | 1 | Oscillator-enable bit |
| sleep_clk_en_i | input | 1 | Select the low-frequency clock as the output source |
| cfg_we_i | input | 1 | Load divide ratio and tail length |
| div_ratio_i | input | DIV_W | Divide ratio to load |
| tail_len_i | input | TAIL_W | Tail length in pulses to load |
| mcu_clk_o | output | 1 | Clock to the microcontroller |
| osc_req_o | output | 1 | Oscillator must be kept running |
| tail_active_o | output | 1 | Tail in progress |

## Verification
The bench counts the tail pulses exactly, including the case where the disable lands right on a rising edge. An off-by-one in the remaining-pulse counter would show up as one pulse too many or too few. A tail of zero is applied in the middle of a high pulse: a design that cut the output at once would leave a runt pulse, and one that ignored the zero would emit a pulse too many. The enable is raised again during a tail to catch a design that drops the oscillator request or restarts the divider. The source is switched into and out of sleep mode while both clocks run, watching for a high pulse shorter than either source could produce. The restart latency and the odd-ratio and clamped-ratio shapes are measured to the exact cycle.

// File: rtl/mco_pkg.sv
package mco_pkg;
  typedef enum logic [1:0] {
    MCO_STOP = 2'd0,
    MCO_RUN  = 2'd1,
    MCO_TAIL = 2'd2
  } mco_state_e;
endpackage

// File: rtl/mco_divider.sv
module mco_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] ratio_i,
  output logic             div_o
);
  logic [DIV_W-1:0] hc_q, hi_len, lo_len, cur_len;
  logic             div_q;

  assign hi_len  = ratio_i >> 1;
  assign lo_len  = ratio_i - hi_len;
  assign cur_len = div_q ? hi_len : lo_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q  <= '0;
      div_q <= 1'b0;
    end else if (!run_i) begin
      hc_q  <= '0;
      div_q <= 1'b0;
    end else if (hc_q >= cur_len - DIV_W'(1)) begin
      hc_q  <= '0;
      div_q <= ~div_q;
    end else begin
      hc_q <= hc_q + DIV_W'(1);
    end
  end

  assign div_o = div_q;

  // R10
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!div_q && hc_q == '0));
endmodule

// File: rtl/mco_src_switch.sv
module mco_src_switch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lf_clk_i,
  input  logic div_i,
  input  logic sleep_sel_i,
  output logic src_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lf_s;
  logic                   sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], lf_clk_i};
  end

  assign lf_s = sync_q[SYNC_STAGES-1];

  // change source only while both candidates are low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              sel_q <= 1'b0;
    else if (!div_i && !lf_s) sel_q <= sleep_sel_i;
  end

  assign src_o = sel_q ? lf_s : div_i;

  // R9
  sel_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != $past(sel_q)) |-> (!$past(div_i) && !$past(lf_s)));
endmodule

// File: rtl/mco_tail_ctrl.sv
module mco_tail_ctrl
  import mco_pkg::*;
#(
  parameter int TAIL_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              src_i,
  input  logic [TAIL_W-1:0] tail_len_i,
  output logic              out_o,
  output logic              run_o,
  output logic              tail_o
);
  mco_state_e        state_q, state_d;
  logic [TAIL_W-1:0] rem_q, rem_d, rem_cur;
  logic              out_q, out_d, rise;

  assign rem_cur = (state_q == MCO_RUN) ? tail_len_i : rem_q;
  assign rise    = src_i & ~out_q;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    out_d   = src_i;
    if (state_q == MCO_STOP) begin
      out_d = 1'b0;
      if (en_i) state_d = MCO_RUN;
    end else if (en_i) begin
      state_d = MCO_RUN;
    end else begin
      state_d = MCO_TAIL;
      rem_d   = rem_cur;
      if (rise) begin
        if (rem_cur == '0) begin
          out_d   = 1'b0;   // suppress the pulse past the tail
          state_d = MCO_STOP;
        end else begin
          rem_d = rem_cur - TAIL_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MCO_STOP;
      rem_q   <= '0;
      out_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      out_q   <= out_d;
    end
  end

  assign out_o  = out_q;
  assign run_o  = (state_q != MCO_STOP);
  assign tail_o = (state_q == MCO_TAIL);

  // R8
  cancel_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MCO_TAIL && en_i) |=> (state_q == MCO_RUN));

  // R6
  req_drop_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_o) |-> (!out_q && !$past(out_q)));

  // R10
  stop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MCO_STOP) |-> !out_q);
endmodule

// File: rtl/mco_clk_out.sv
module mco_clk_out #(
  parameter int DIV_W       = 8,
  parameter int TAIL_W      = 10,
  parameter int DIV_DEF     = 10,
  parameter int TAIL_DEF    = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lf_clk_i,
  input  logic              osc_en_i,
  input  logic              sleep_clk_en_i,
  input  logic              cfg_we_i,
  input  logic [DIV_W-1:0]  div_ratio_i,
  input  logic [TAIL_W-1:0] tail_len_i,
  output logic              mcu_clk_o,
  output logic              osc_req_o,
  output logic              tail_active_o
);
  localparam int MIN_DIV = 2;

  logic [DIV_W-1:0]  ratio_q;
  logic [TAIL_W-1:0] tail_q;
  logic              div_clk, src_clk, run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= DIV_W'(DIV_DEF);
      tail_q  <= TAIL_W'(TAIL_DEF);
    end else if (cfg_we_i) begin
      ratio_q <= (div_ratio_i < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_ratio_i;
      tail_q  <= tail_len_i;
    end
  end

  mco_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .ratio_i (ratio_q),
    .div_o   (div_clk)
  );

  mco_src_switch #(.SYNC_STAGES(SYNC_STAGES)) u_sw (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lf_clk_i    (lf_clk_i),
    .div_i       (div_clk),
    .sleep_sel_i (sleep_clk_en_i),
    .src_o       (src_clk)
  );

  mco_tail_ctrl #(.TAIL_W(TAIL_W)) u_tail (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (osc_en_i),
    .src_i      (src_clk),
    .tail_len_i (tail_q),
    .out_o      (mcu_clk_o),
    .run_o      (run),
    .tail_o     (tail_active_o)
  );

  assign osc_req_o = run;

  // R4
  ratio_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_q >= DIV_W'(MIN_DIV));
endmodule

// File: tb/mco_clk_out_tb_top.sv
`timescale 1ns/1ps
module mco_clk_out_tb_top;
  localparam int DIV_W  = 8;
  localparam int TAIL_W = 10;
  localparam int LF_HALF = 20;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic lf_clk_i = 1'b0;
  logic osc_en_i = 1'b0;
  logic sleep_clk_en_i = 1'b0;
  logic cfg_we_i = 1'b0;
  logic [DIV_W-1:0]  div_ratio_i = '0;
  logic [TAIL_W-1:0] tail_len_i = '0;
  logic mcu_clk_o, osc_req_o, tail_active_o;

  int checks = 0;
  int failures = 0;
  int lf_cnt = 0;

  always #4 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (lf_cnt == LF_HALF - 1) begin
      lf_cnt   <= 0;
      lf_clk_i <= ~lf_clk_i;
    end else begin
      lf_cnt <= lf_cnt + 1;
    end
  end

  mco_clk_out #(.DIV_W(DIV_W), .TAIL_W(TAIL_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .lf_clk_i(lf_clk_i), .osc_en_i(osc_en_i),
    .sleep_clk_en_i(sleep_clk_en_i), .cfg_we_i(cfg_we_i), .div_ratio_i(div_ratio_i),
    .tail_len_i(tail_len_i), .mcu_clk_o(mcu_clk_o), .osc_req_o(osc_req_o),
    .tail_active_o(tail_active_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int r, input int t);
    @(negedge clk_i);
    div_ratio_i = DIV_W'(r);
    tail_len_i  = TAIL_W'(t);
    cfg_we_i    = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic measure(output int hi, output int lo);
    hi = 0; lo = 0;
    for (int i = 0; i < 2000 && mcu_clk_o !== 1'b0; i++) @(negedge clk_i);
    for (int i = 0; i < 2000 && mcu_clk_o !== 1'b1; i++) @(negedge clk_i);
    for (int i = 0; i < 2000 && mcu_clk_o === 1'b1; i++) begin hi++; @(negedge clk_i); end
    for (int i = 0; i < 2000 && mcu_clk_o === 1'b0; i++) begin lo++; @(negedge clk_i); end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    chk("R1 clk low in reset", mcu_clk_o, 0);
    chk("R1 req low in reset", osc_req_o, 0);
    chk("R1 tail low in reset", tail_active_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask

  // R10: restart latency from the stopped state
  task automatic t_start(input int r);
    int n;
    int lo_len;
    lo_len = r - r / 2;
    n = 0;
    @(negedge clk_i);
    osc_en_i = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      n++;
      if (n == 1) chk("R10 req after enable", osc_req_o, 1);
      if (mcu_clk_o) break;
    end
    chk("R10 first pulse latency", n, lo_len + 2);
  endtask

  task automatic t_shape(input string tag, input int hi_e, input int lo_e);
    int hi, lo;
    measure(hi, lo);
    measure(hi, lo);
    chk({tag, " high time"}, hi, hi_e);
    chk({tag, " low time"}, lo, lo_e);
  endtask

  // R5 R6: tail pulse count and request release
  task automatic t_tail(input string tag, input int n_exp);
    int rises, prev, prev2, first;
    rises = 0;
    @(negedge clk_i);
    prev = mcu_clk_o;
    prev2 = prev;
    osc_en_i = 1'b0;
    first = 1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk_i);
      if (first == 1) begin
        chk({tag, " R5 tail flag"}, tail_active_o, 1);
        first = 0;
      end
      if (!osc_req_o) break;
      if (mcu_clk_o && !prev) rises++;
      prev2 = prev;
      prev = mcu_clk_o;
    end
    chk({tag, " R5 tail pulses"}, rises, n_exp);
    chk({tag, " R6 clk low at release"}, mcu_clk_o, 0);
    chk({tag, " R6 clk low before release"}, prev, 0);
    chk({tag, " R6 tail flag cleared"}, tail_active_o, 0);
  endtask

  task automatic t_quiet();
    int bad;
    bad = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i);
      if (mcu_clk_o || osc_req_o) bad++;
    end
    chk("R10 output parked while stopped", bad, 0);
  endtask

  // R7: zero tail while a high pulse is in progress
  task automatic t_tail_zero(input int hi_e);
    int ones, rises, prev;
    for (int i = 0; i < 2000 && mcu_clk_o !== 1'b0; i++) @(negedge clk_i);
    for (int i = 0; i < 2000 && mcu_clk_o !== 1'b1; i++) @(negedge clk_i);
    osc_en_i = 1'b0;
    ones = 1; rises = 0; prev = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      if (!osc_req_o) break;
      if (mcu_clk_o) ones++;
      if (mcu_clk_o && !prev) rises++;
      prev = mcu_clk_o;
    end
    chk("R7 no new pulse", rises, 0);
    chk("R7 pulse completes", ones, hi_e);
    chk("R7 stopped", osc_req_o, 0);
  endtask

  // R8: re-enable during tail
  task automatic t_cancel();
    int drops;
    drops = 0;
    @(negedge clk_i);
    osc_en_i = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      if (!osc_req_o) drops++;
    end
    chk("R8 in tail before cancel", tail_active_o, 1);
    osc_en_i = 1'b1;
    @(negedge clk_i);
    chk("R8 tail flag cleared", tail_active_o, 0);
    for (int i = 0; i < 50; i++) begin
      if (!osc_req_o) drops++;
      @(negedge clk_i);
    end
    chk("R8 request never dropped", drops, 0);
  endtask

  // R9: source switching without runts
  task automatic track_min(input int cycles, inout int min_hi);
    int run, started;
    run = 0; started = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      if (!mcu_clk_o) begin
        if (started && run > 0 && run < min_hi) min_hi = run;
        run = 0;
        started = 1;
      end else if (started) begin
        run++;
      end
    end
  endtask

  task automatic t_sleep();
    int min_hi;
    min_hi = 1000;
    @(negedge clk_i);
    sleep_clk_en_i = 1'b1;
    track_min(400, min_hi);
    t_shape("R9 sleep clock", LF_HALF, LF_HALF);
    @(negedge clk_i);
    sleep_clk_en_i = 1'b0;
    track_min(300, min_hi);
    t_shape("R9 back to divided", 3, 3);
    chk("R9 no runt pulse", (min_hi >= 3) ? 1 : 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_start(10);                 // R2 default ratio
    t_shape("R2 R3 default ratio", 5, 5);
    t_tail("R2 default tail", 128);
    t_quiet();
    cfg(7, 5);                   // R4 load while stopped
    t_start(7);
    t_shape("R3 R4 odd ratio", 3, 4);
    t_tail("R4 loaded tail", 5);
    cfg(1, 3);
    t_start(2);
    t_shape("R4 ratio clamp", 1, 1);
    t_tail("R5 short ratio", 3);
    cfg(8, 0);
    t_start(8);
    t_tail_zero(4);
    cfg(8, 50);
    t_start(8);
    t_cancel();
    t_shape("R8 divided output resumes", 4, 4);
    cfg(6, 50);                  // R4 load while running
    t_shape("R3 R4 even ratio", 3, 3);
    t_sleep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule